// File: doc/BRIEF.md
# Storage Host Adapter Mailbox Register Block

This block is the host-facing 32-bit register file of a storage host adapter. Software reads a status word that packs the firmware state together with the adapter's scatter-gather and command limits. It programs an interrupt mask and acknowledges completions through a doorbell counter. It posts work by writing a frame pointer to a queue port, which the block turns into a frame address and a frame count. A downstream frame engine receives these as a single-cycle request.

The block also tracks the firmware state, which is either READY or OPERATIONAL. Before the adapter is operational, the block does not forward frames. It accepts only an initialisation frame and answers any other frame with a not-initialised code. The completion path raises a one-cycle pulse for each finished command. The pulse increments the doorbell count and, while interrupts are unmasked, drives a level interrupt. A management-command path can signal a controller shutdown, which returns the firmware to READY.

All register reads are combinational from the current state. All writes, and every registered output, take effect at the clock edge that samples the write.

Top module: `hba_mbox_regs`

## Requirements
- R1: After reset, the firmware state is READY (0xB), the mask is 0xFFFFFFFF, the doorbell count is 0, and irq, frm_req, reply_valid and abort_req are low.
- R2: Reads of offset 0x18 and offset 0xB0 return the status word: state in bits 31:28, zero in bits 27:24, the scatter-gather limit (SGE_MAX) in bits 23:16, and the command limit (CMD_MAX) in bits 15:0.
- R3: Offset 0x34 reads back the last value written to it. Interrupts are enabled exactly when the mask is not 0xFFFFFFFF. Writing 0xFFFFFFFF drops irq at that edge. Unmasking alone never raises irq.
- R4: Each cycle with done_pulse high increments the doorbell count by one, saturating at 2^CNT_W-1. If interrupts are enabled after that edge, irq goes high and stays high until it is cleared, masked or soft-reset.
- R5: A read of offset 0x30 returns 0x80000000 ORed with the count when interrupts are enabled and the count is nonzero. Otherwise it returns 0.
- R6: A write to offset 0xA0 zeroes the count and drops irq. A read of 0xA0 returns the count. A done_pulse in the same cycle as the clear leaves the count at 1, with irq high if interrupts are enabled.
- R7: A write to offset 0x20 with bit 1 set is a soft reset: state READY, count 0, mask 0xFFFFFFFF, irq low. Bit 0 set raises abort_req for one cycle and changes no other state.
- R8: In OPERATIONAL state (0xC), a write to offset 0x40 raises frm_req for exactly one cycle, with frm_addr equal to the value with bits 3:0 cleared and frm_count equal to bits 3:1. No reply is produced.
- R9: Outside OPERATIONAL, a write to 0x40 produces no frm_req and a one-cycle reply_valid. If frm_opcode is 0x00, reply_code is 0x00 and the state becomes OPERATIONAL. For any other opcode, reply_code is 0x08 and the state is unchanged.
- R10: mgmt_valid with mgmt_opcode 0x01050000 sets the state to READY. Any other management opcode has no effect.
- R11: Reads of 0x20 and of every offset not listed above return 0. Writes to offsets other than 0x20, 0x34, 0x40 and 0xA0 change no state.
- R12: A soft reset wins over a done_pulse in the same cycle, leaving the count at 0 and irq low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| frm_opcode | input | 8 | Opcode of the frame being posted, valid with a queue-port write |
| done_pulse | input | 1 | One pulse per completed command |
| mgmt_valid | input | 1 | Management command decoded this cycle |
| mgmt_opcode | input | 32 | Management command opcode |
| frm_req | output | 1 | One-cycle frame request to the frame engine |
| frm_addr | output | 32 | Frame address, 16-byte aligned |
| frm_count | output | 3 | Frame count from the queue-port write |
| reply_valid | output | 1 | One-cycle local reply for a frame posted before operational |
| reply_code | output | 8 | Local reply status code |
| abort_req | output | 1 | One-cycle request to abort all pending commands |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check the following: irq is never high while masked or with a zero count, the count steps by exactly one per unblocked pulse, and a frame request and a local reply never coincide. They also check that the state only holds READY or OPERATIONAL, and that a soft reset always restores the READY, masked, zero-count state. Only the bench scenarios can show the rest. This covers the exact read values across the whole offset space, field extraction from the queue-port value for every frame count, and the init gating sequence with its reply codes. It also covers the ordering cases: clear with a pulse, soft reset with a pulse, unmasking without a new pulse, and saturation of a narrow counter.

// File: rtl/hba_mbox_pkg.sv
package hba_mbox_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [3:0] {
        FW_READY = 4'hB,
        FW_OPER  = 4'hC
    } fw_state_e;

    // Register byte offsets
    localparam int OFF_STAT_A   = 'h18;
    localparam int OFF_DB_IN    = 'h20;
    localparam int OFF_INT_STAT = 'h30;
    localparam int OFF_INT_MASK = 'h34;
    localparam int OFF_QPORT    = 'h40;
    localparam int OFF_DB_CLR   = 'hA0;
    localparam int OFF_STAT_B   = 'hB0;

    localparam logic [DATA_W-1:0] MASK_ALL   = '1;
    localparam logic [7:0]        OP_INIT    = 8'h00;
    localparam logic [7:0]        RC_OK      = 8'h00;
    localparam logic [7:0]        RC_NO_INIT = 8'h08;
    localparam logic [31:0]       MGMT_SHUTDN = 32'h0105_0000;

    typedef struct packed {
        logic soft_rst;
        logic abort;
        logic mask_wr;
        logic clr_wr;
        logic qport_wr;
    } mbox_wr_t;

    function automatic logic [DATA_W-1:0] status_word(
        input logic [3:0] st, input int sge, input int cmds);
        return {st, 4'h0, 8'(sge), 16'(cmds)};
    endfunction

endpackage

// File: rtl/hba_mbox_dec.sv
module hba_mbox_dec
    import hba_mbox_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        wdata_lo,
    output mbox_wr_t          sel
);

    logic hit_db;

    always_comb begin
        hit_db       = wr_en && (addr == ADDR_W'(OFF_DB_IN));
        sel.soft_rst = hit_db && wdata_lo[1];
        sel.abort    = hit_db && wdata_lo[0];
        sel.mask_wr  = wr_en && (addr == ADDR_W'(OFF_INT_MASK));
        sel.clr_wr   = wr_en && (addr == ADDR_W'(OFF_DB_CLR));
        sel.qport_wr = wr_en && (addr == ADDR_W'(OFF_QPORT));
    end

endmodule

// File: rtl/hba_mbox_fw_ctl.sv
module hba_mbox_fw_ctl
    import hba_mbox_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        soft_rst,
    input  logic        abort_wr,
    input  logic        qport_wr,
    input  logic [31:1] wdata_hi,
    input  logic [7:0]  frm_opcode,
    input  logic        mgmt_valid,
    input  logic [31:0] mgmt_opcode,
    output fw_state_e   fw_state,
    output logic        frm_req,
    output logic [31:0] frm_addr,
    output logic [2:0]  frm_count,
    output logic        reply_valid,
    output logic [7:0]  reply_code,
    output logic        abort_req
);

    logic is_oper;
    logic is_init;
    logic shutdown;

    always_comb begin
        is_oper  = (fw_state == FW_OPER);
        is_init  = (frm_opcode == OP_INIT);
        shutdown = mgmt_valid && (mgmt_opcode == MGMT_SHUTDN);
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            fw_state <= FW_READY;
        end else if (shutdown) begin
            fw_state <= FW_READY;
        end else if (qport_wr && !is_oper && is_init) begin
            fw_state <= FW_OPER;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_req     <= 1'b0;
            frm_addr    <= '0;
            frm_count   <= '0;
            reply_valid <= 1'b0;
            reply_code  <= '0;
            abort_req   <= 1'b0;
        end else begin
            frm_req     <= qport_wr && is_oper;
            reply_valid <= qport_wr && !is_oper;
            abort_req   <= abort_wr;
            if (qport_wr) begin
                frm_addr   <= {wdata_hi[31:4], 4'h0};
                frm_count  <= wdata_hi[3:1];
                reply_code <= is_init ? RC_OK : RC_NO_INIT;
            end
        end
    end

    // R9
    state_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (fw_state == FW_READY) || (fw_state == FW_OPER));

    // R8
    req_reply_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(frm_req && reply_valid));

endmodule

// File: rtl/hba_mbox_doorbell.sv
module hba_mbox_doorbell
    import hba_mbox_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              mask_wr,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done_pulse,
    output logic [DATA_W-1:0] mask_q,
    output logic [CNT_W-1:0]  cnt,
    output logic              intr_en,
    output logic              irq
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [DATA_W-1:0] mask_nx;
    logic              en_nx;
    logic [CNT_W-1:0]  base;
    logic [CNT_W-1:0]  cnt_nx;

    always_comb begin
        mask_nx = mask_wr ? wdata : mask_q;
        en_nx   = (mask_nx != MASK_ALL);
        base    = clr_wr ? '0 : cnt;
        cnt_nx  = (done_pulse && base != CNT_MAX) ? base + CNT_W'(1) : base;
        intr_en = (mask_q != MASK_ALL);
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            mask_q <= MASK_ALL;
            cnt    <= '0;
            irq    <= 1'b0;
        end else begin
            mask_q <= mask_nx;
            cnt    <= cnt_nx;
            if (done_pulse && en_nx) begin
                irq <= 1'b1;
            end else if (clr_wr || !en_nx) begin
                irq <= 1'b0;
            end
        end
    end

    // R3
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> intr_en);

    // R6
    irq_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cnt != '0));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (done_pulse && !clr_wr && !soft_rst && cnt != CNT_MAX)
        |=> (cnt == $past(cnt) + CNT_W'(1)));

endmodule

// File: rtl/hba_mbox_rd_mux.sv
module hba_mbox_rd_mux
    import hba_mbox_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int CNT_W   = 16,
    parameter int SGE_MAX = 8,
    parameter int CMD_MAX = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        state,
    input  logic [DATA_W-1:0] mask_q,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              intr_en,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] MSG_FLAG = 32'h8000_0000;

    logic [DATA_W-1:0] cnt_ext;

    always_comb begin
        cnt_ext = DATA_W'(cnt);
        rdata   = '0;
        case (addr)
            ADDR_W'(OFF_STAT_A),
            ADDR_W'(OFF_STAT_B):   rdata = status_word(state, SGE_MAX, CMD_MAX);
            ADDR_W'(OFF_INT_STAT): rdata = (intr_en && cnt != '0) ? (MSG_FLAG | cnt_ext) : '0;
            ADDR_W'(OFF_INT_MASK): rdata = mask_q;
            ADDR_W'(OFF_DB_CLR):   rdata = cnt_ext;
            default:               rdata = '0;
        endcase
    end

endmodule

// File: rtl/hba_mbox_regs.sv
module hba_mbox_regs
    import hba_mbox_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int CNT_W   = 16,
    parameter int SGE_MAX = 8,
    parameter int CMD_MAX = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [7:0]        frm_opcode,
    input  logic              done_pulse,
    input  logic              mgmt_valid,
    input  logic [31:0]       mgmt_opcode,
    output logic              frm_req,
    output logic [31:0]       frm_addr,
    output logic [2:0]        frm_count,
    output logic              reply_valid,
    output logic [7:0]        reply_code,
    output logic              abort_req,
    output logic              irq
);

    mbox_wr_t          sel;
    fw_state_e         fw_state;
    logic [DATA_W-1:0] mask_q;
    logic [CNT_W-1:0]  cnt;
    logic              intr_en;

    hba_mbox_dec #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata_lo (reg_wdata[1:0]),
        .sel      (sel)
    );

    hba_mbox_fw_ctl u_fw (
        .clk         (clk),
        .rst         (rst),
        .soft_rst    (sel.soft_rst),
        .abort_wr    (sel.abort),
        .qport_wr    (sel.qport_wr),
        .wdata_hi    (reg_wdata[31:1]),
        .frm_opcode  (frm_opcode),
        .mgmt_valid  (mgmt_valid),
        .mgmt_opcode (mgmt_opcode),
        .fw_state    (fw_state),
        .frm_req     (frm_req),
        .frm_addr    (frm_addr),
        .frm_count   (frm_count),
        .reply_valid (reply_valid),
        .reply_code  (reply_code),
        .abort_req   (abort_req)
    );

    hba_mbox_doorbell #(.CNT_W(CNT_W)) u_db (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (sel.soft_rst),
        .mask_wr    (sel.mask_wr),
        .clr_wr     (sel.clr_wr),
        .wdata      (reg_wdata),
        .done_pulse (done_pulse),
        .mask_q     (mask_q),
        .cnt        (cnt),
        .intr_en    (intr_en),
        .irq        (irq)
    );

    hba_mbox_rd_mux #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .SGE_MAX (SGE_MAX),
        .CMD_MAX (CMD_MAX)
    ) u_rd (
        .addr    (reg_addr),
        .state   (fw_state),
        .mask_q  (mask_q),
        .cnt     (cnt),
        .intr_en (intr_en),
        .rdata   (reg_rdata)
    );

    // R7
    soft_rst_chk: assert property (@(posedge clk) disable iff (rst)
        sel.soft_rst |=> (fw_state == FW_READY && mask_q == MASK_ALL
                          && cnt == '0 && !irq));

    // R12
    srst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (sel.soft_rst && done_pulse) |=> (cnt == '0));

endmodule

// File: tb/hba_mbox_regs_bench.sv
module hba_mbox_regs_bench;

    localparam int CW      = 4;
    localparam int CNT_TOP = (1 << CW) - 1;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  frm_opcode = '0;
    logic        done_pulse = 1'b0;
    logic        mgmt_valid = 1'b0;
    logic [31:0] mgmt_opcode = '0;
    logic        frm_req;
    logic [31:0] frm_addr;
    logic [2:0]  frm_count;
    logic        reply_valid;
    logic [7:0]  reply_code;
    logic        abort_req;
    logic        irq;

    always #10 clk = ~clk;

    hba_mbox_regs #(.ADDR_W(8), .CNT_W(CW), .SGE_MAX(8), .CMD_MAX(64)) u_hba_mbox_regs (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frm_opcode(frm_opcode),
        .done_pulse(done_pulse), .mgmt_valid(mgmt_valid), .mgmt_opcode(mgmt_opcode),
        .frm_req(frm_req), .frm_addr(frm_addr), .frm_count(frm_count),
        .reply_valid(reply_valid), .reply_code(reply_code),
        .abort_req(abort_req), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Requirement-level model
    logic [3:0]  m_state;
    logic [31:0] m_mask;
    int          m_cnt;
    bit          m_irq;

    // Pulse outputs captured right after a write edge
    logic        c_req, c_rv, c_abort;
    logic [31:0] c_addr;
    logic [2:0]  c_cnt;
    logic [7:0]  c_code;

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h18, 8'hB0: return {m_state, 4'h0, 8'd8, 16'd64};
            8'h30: return (m_mask != ONES && m_cnt != 0) ? (32'h8000_0000 | 32'(m_cnt)) : 32'h0;
            8'h34: return m_mask;
            8'hA0: return 32'(m_cnt);
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a);
        reg_addr = a;
        #1;
        chk(req, $sformatf("read 0x%02h", a), reg_rdata, exp_rd(a));
    endtask

    task automatic sweep_reads(input string req);
        for (int a = 0; a < 256; a += 4) rd_chk(req, 8'(a));
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d,
                      input logic [7:0] op, input bit pulse);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        frm_opcode = op; done_pulse = pulse;
        @(negedge clk);
        c_req = frm_req; c_rv = reply_valid; c_abort = abort_req;
        c_addr = frm_addr; c_cnt = frm_count; c_code = reply_code;
        reg_wr_en = 1'b0; done_pulse = 1'b0;
    endtask

    task automatic pulses(input int n);
        @(negedge clk);
        done_pulse = 1'b1;
        repeat (n) @(negedge clk);
        done_pulse = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (m_cnt < CNT_TOP) m_cnt++;
            if (m_mask != ONES) m_irq = 1'b1;
        end
    endtask

    task automatic mgmt(input logic [31:0] op);
        @(negedge clk);
        mgmt_valid = 1'b1; mgmt_opcode = op;
        @(negedge clk);
        mgmt_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_state = 4'hB; m_mask = ONES; m_cnt = 0; m_irq = 1'b0;

        // R1 reset values, R2 status word, R11 zero elsewhere
        chk("R1", "irq", 32'(irq), 0);
        chk("R1", "frm_req", 32'(frm_req), 0);
        chk("R1", "reply_valid", 32'(reply_valid), 0);
        chk("R1", "abort_req", 32'(abort_req), 0);
        sweep_reads("R1");
        rd_chk("R2", 8'hB0);

        // R3 mask write, R5 status with zero count
        wr(8'h34, 32'h0, 8'h0, 1'b0); m_mask = 32'h0;
        rd_chk("R3", 8'h34);
        rd_chk("R5", 8'h30);

        // R4 pulses raise irq
        pulses(3);
        chk("R4", "irq after pulses", 32'(irq), 32'(m_irq));
        rd_chk("R5", 8'h30);
        rd_chk("R6", 8'hA0);

        // R3 masking drops irq, R5 reads zero while masked
        wr(8'h34, ONES, 8'h0, 1'b0); m_mask = ONES; m_irq = 1'b0;
        chk("R3", "irq masked", 32'(irq), 0);
        rd_chk("R5", 8'h30);
        rd_chk("R6", 8'hA0);
        wr(8'h34, 32'h1, 8'h0, 1'b0); m_mask = 32'h1;
        chk("R3", "unmask no raise", 32'(irq), 0);
        pulses(1);
        chk("R4", "irq after unmask+pulse", 32'(irq), 1);

        // R6 clear, and clear with simultaneous pulse
        wr(8'hA0, 32'h0, 8'h0, 1'b0); m_cnt = 0; m_irq = 1'b0;
        chk("R6", "irq after clear", 32'(irq), 0);
        rd_chk("R6", 8'hA0);
        pulses(2);
        wr(8'hA0, 32'h0, 8'h0, 1'b1); m_cnt = 1; m_irq = 1'b1;
        chk("R6", "irq clear+pulse", 32'(irq), 1);
        rd_chk("R6", 8'hA0);

        // R4 saturation of the count
        pulses(20);
        rd_chk("R4", 8'hA0);
        rd_chk("R5", 8'h30);
        wr(8'hA0, 32'h0, 8'h0, 1'b0); m_cnt = 0; m_irq = 1'b0;

        // R9 gating before operational
        wr(8'h40, 32'h1234_5678, 8'h05, 1'b0);
        chk("R9", "reply_valid", 32'(c_rv), 1);
        chk("R9", "reply_code", 32'(c_code), 32'h08);
        chk("R9", "no frm_req", 32'(c_req), 0);
        rd_chk("R9", 8'h18);
        wr(8'h40, 32'h0000_1000, 8'h00, 1'b0); m_state = 4'hC;
        chk("R9", "init reply_valid", 32'(c_rv), 1);
        chk("R9", "init reply_code", 32'(c_code), 32'h00);
        chk("R9", "init no frm_req", 32'(c_req), 0);
        rd_chk("R9", 8'h18);

        // R8 field extraction sweep
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 4; k++) begin
                logic [31:0] v;
                v = (32'hA5A5_0000 ^ (32'(k) << 8) ^ (32'(c) << 20));
                v[3:1] = 3'(c);
                v[0] = k[0];
                wr(8'h40, v, (k[1] ? 8'h05 : 8'h00), 1'b0);
                chk("R8", "frm_req", 32'(c_req), 1);
                chk("R8", "frm_addr", c_addr, v & 32'hFFFF_FFF0);
                chk("R8", "frm_count", 32'(c_cnt), 32'(c));
                chk("R8", "no reply", 32'(c_rv), 0);
            end
        end
        @(negedge clk);
        chk("R8", "frm_req one cycle", 32'(frm_req), 0);
        rd_chk("R8", 8'h18);

        // R10 management commands
        mgmt(32'h0105_0001);
        rd_chk("R10", 8'h18);
        mgmt(32'h0105_0000); m_state = 4'hB;
        rd_chk("R10", 8'h18);
        wr(8'h40, 32'h0000_2000, 8'h03, 1'b0);
        chk("R10", "gated again reply", 32'(c_code), 32'h08);
        chk("R10", "gated again no req", 32'(c_req), 0);

        // R7 abort bit
        wr(8'h34, 32'h0, 8'h0, 1'b0); m_mask = 32'h0;
        pulses(2);
        wr(8'h20, 32'h1, 8'h0, 1'b0);
        chk("R7", "abort_req", 32'(c_abort), 1);
        rd_chk("R7", 8'h30);
        rd_chk("R7", 8'h34);
        @(negedge clk);
        chk("R7", "abort one cycle", 32'(abort_req), 0);

        // R12 soft reset with simultaneous pulse, R7 soft reset values
        wr(8'h40, 32'h0, 8'h00, 1'b0); m_state = 4'hC;
        wr(8'h20, 32'h2, 8'h0, 1'b1);
        m_state = 4'hB; m_mask = ONES; m_cnt = 0; m_irq = 1'b0;
        chk("R12", "irq after soft reset", 32'(irq), 0);
        chk("R7", "no abort on bit1", 32'(c_abort), 0);
        sweep_reads("R12");

        // R11 writes to other offsets change nothing
        wr(8'h34, 32'h0, 8'h0, 1'b0); m_mask = 32'h0;
        pulses(1);
        for (int a = 0; a < 256; a += 4) begin
            if (a != 'h20 && a != 'h34 && a != 'h40 && a != 'hA0) begin
                wr(8'(a), ONES, 8'h00, 1'b0);
                if (c_req || c_rv || c_abort)
                    chk("R11", $sformatf("strobe from 0x%02h", a), 32'h1, 32'h0);
            end
        end
        chk("R11", "irq kept", 32'(irq), 1);
        sweep_reads("R11");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule